// File: doc/BRIEF.md
# Multi-Depth Pixel Serialiser

This block takes one byte of video data at a time and turns it into a stream of palette indices. It supports four colour depths: 1, 2, 4 or 8 bits per pixel. A byte therefore yields 8, 4, 2 or 1 pixels. The most significant group of bits leaves first. Each index is presented zero-extended on an 8-bit output that feeds a colour palette.

A load strobe captures a new byte together with the depth selected at that moment. A per-pixel advance enable then steps to the next group. A display-enable input blanks the output during borders and retrace.

The output is combinational from the held state. A byte loaded on one clock edge shows its first pixel for the whole of the following cycle. Each advance edge exposes the next pixel.

Top module: `pix_serializer`

## Requirements
- R1: While reset is asserted and after it is released with no load, the held byte is zero and `index_o` reads 0.
- R2: Depth code 0 gives one bit per pixel: pixels are d7, d6, ..., d0 in that order, placed at `index_o[0]` with bits 7..1 zero.
- R3: Depth code 1 gives two bits per pixel: pixels are {d7,d6}, {d5,d4}, {d3,d2}, {d1,d0} in that order, with the odd-numbered bit at `index_o[1]`, bits 7..2 zero.
- R4: Depth code 2 gives four bits per pixel: d7..d4 first, then d3..d0, on `index_o[3:0]`, bits 7..4 zero.
- R5: Depth code 3 gives the whole byte d7..d0 as a single pixel on `index_o[7:0]`.
- R6: When `load_i` and `adv_i` are both high on one edge, the load wins: the next cycle shows the first pixel of the new byte.
- R7: With `de_i` low, `index_o` is 0, and the held state is unaffected, so raising `de_i` again shows the pixel that was pending.
- R8: The depth is sampled only on a load; changing `mode_i` between loads does not change how the held byte is split.
- R9: Once all pixels of a byte have been advanced past, further advances give index 0 until the next load.
- R10: With neither `load_i` nor `adv_i` high, the displayed pixel holds from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture `data_i` and `mode_i` on this edge |
| data_i | input | 8 | Video data byte |
| mode_i | input | 2 | Depth code: 0=1, 1=2, 2=4, 3=8 bits per pixel |
| adv_i | input | 1 | Pixel enable: step to the next pixel on this edge |
| de_i | input | 1 | Display enable; low forces the index to zero |
| index_o | output | 8 | Palette index of the current pixel |

## Verification
Corrupted held state appears directly on `index_o`. Because the output is combinational from the held state, the error shows in the same cycle as the wrong pixel: a misordered group, a stale bit or a non-zero upper bit. A wrong latched depth splits every following pixel of that byte incorrectly, beginning with the first cycle after the load. A failure to shift or a stray shift shows up one cycle after the advance edge as a repeated or skipped pixel. The scoreboard detects it there.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEPTH_W = 2;

  typedef enum logic [DEPTH_W-1:0] {
    PXS_1B = 2'd0,
    PXS_2B = 2'd1,
    PXS_4B = 2'd2,
    PXS_8B = 2'd3
  } pxs_depth_e;

  // leading group of the held byte, zero-extended to a full index
  function automatic logic [BYTE_W-1:0] head_group(input logic [BYTE_W-1:0] s,
                                                   input pxs_depth_e d);
    logic [BYTE_W-1:0] r;
    r = '0;
    case (d)
      PXS_1B: r[0]   = s[BYTE_W-1];
      PXS_2B: r[1:0] = s[BYTE_W-1 -: 2];
      PXS_4B: r[3:0] = s[BYTE_W-1 -: 4];
      default: r     = s;
    endcase
    return r;
  endfunction

  // held byte after one pixel has been consumed
  function automatic logic [BYTE_W-1:0] drop_group(input logic [BYTE_W-1:0] s,
                                                   input pxs_depth_e d);
    logic [BYTE_W-1:0] r;
    case (d)
      PXS_1B: r = {s[BYTE_W-2:0], 1'b0};
      PXS_2B: r = {s[BYTE_W-3:0], 2'b00};
      PXS_4B: r = {s[BYTE_W-5:0], 4'b0000};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pxs_shreg.sv
module pxs_shreg
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [DEPTH_W-1:0] mode_i,
  input  logic              adv_i,
  output logic [BYTE_W-1:0] sreg_o,
  output pxs_depth_e        depth_o,
  output logic              load_evt_o,
  output logic              shift_evt_o
);
  logic [BYTE_W-1:0] sreg_q;
  pxs_depth_e        depth_q;

  assign load_evt_o  = load_i;
  assign shift_evt_o = adv_i & ~load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      depth_q <= PXS_1B;
    end else if (load_evt_o) begin
      sreg_q  <= data_i;
      depth_q <= pxs_depth_e'(mode_i);
    end else if (shift_evt_o) begin
      sreg_q  <= drop_group(sreg_q, depth_q);
    end
  end

  assign sreg_o  = sreg_q;
  assign depth_o = depth_q;
endmodule

// File: rtl/pxs_select.sv
module pxs_select
  import pxs_pkg::*;
(
  input  logic [BYTE_W-1:0] sreg_i,
  input  pxs_depth_e        depth_i,
  input  logic              de_i,
  output logic [BYTE_W-1:0] index_o
);
  logic [BYTE_W-1:0] group_w;

  always_comb begin
    group_w = head_group(sreg_i, depth_i);
    index_o = de_i ? group_w : '0;
  end
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [7:0]        data_i,
  input  logic [1:0]        mode_i,
  input  logic              adv_i,
  input  logic              de_i,
  output logic [7:0]        index_o
);
  logic [BYTE_W-1:0] sreg_w;
  pxs_depth_e        depth_w;
  logic              load_evt;
  logic              shift_evt;

  pxs_shreg u_shreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .data_i     (data_i),
    .mode_i     (mode_i),
    .adv_i      (adv_i),
    .sreg_o     (sreg_w),
    .depth_o    (depth_w),
    .load_evt_o (load_evt),
    .shift_evt_o(shift_evt)
  );

  pxs_select u_select (
    .sreg_i (sreg_w),
    .depth_i(depth_w),
    .de_i   (de_i),
    .index_o(index_o)
  );
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic       adv_i,
  input logic       de_i,
  input logic [7:0] data_i,
  input logic [7:0] index_o,
  input logic [7:0] sreg_q,
  input logic [1:0] mode_q,
  input logic       shift_evt
);
  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |-> index_o == 8'd0);

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sreg_q == $past(data_i));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(sreg_q) && $stable(mode_q)));

  assert_depth_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mode_q));

  assert_single_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && mode_q == 2'd3) |=> sreg_q == 8'd0);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> index_o[7:1] == 7'd0);
endmodule

bind pix_serializer pxs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .adv_i    (adv_i),
  .de_i     (de_i),
  .data_i   (data_i),
  .index_o  (index_o),
  .sreg_q   (sreg_w),
  .mode_q   (depth_w),
  .shift_evt(shift_evt)
);

// File: tb/pix_serializer_bench.sv
`timescale 1ns/1ps
module pix_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] data_i = 8'd0;
  logic [1:0] mode_i = 2'd0;
  logic       adv_i = 1'b0;
  logic       de_i = 1'b1;
  logic [7:0] index_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  // reference model: byte, depth and pixel number since the load
  logic [7:0] m_byte = 8'd0;
  logic [1:0] m_mode = 2'd0;
  int         m_k = 0;

  always #2.5 clk = ~clk;

  pix_serializer u_pix_serializer (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .mode_i(mode_i), .adv_i(adv_i), .de_i(de_i), .index_o(index_o)
  );

  function automatic logic [7:0] ref_pix(logic [7:0] b, logic [1:0] m, int k);
    int bpp, npix;
    logic [7:0] v;
    bpp  = 1 << m;
    npix = 8 / bpp;
    v = 8'd0;
    if (k < npix)
      for (int j = 0; j < bpp; j++) v[j] = b[8 - bpp*(k+1) + j];
    return v;
  endfunction

  task automatic cyc(input logic ld, input logic [7:0] b, input logic [1:0] m,
                     input logic adv, input logic de, input string tag);
    item_t it;
    @(negedge clk);
    load_i = ld; data_i = b; mode_i = m; adv_i = adv; de_i = de;
    it.exp = de ? ref_pix(m_byte, m_mode, m_k) : 8'd0;
    it.tag = tag;
    sb.push_back(it);
    if (ld) begin
      m_byte = b; m_mode = m; m_k = 0;
    end else if (adv && m_k < 8) begin
      m_k = m_k + 1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (index_o !== it.exp) begin
        bad++;
        $display("FAIL %s: index_o=%02h expected=%02h", it.tag, index_o, it.exp);
      end
    end
  end

  task automatic run_byte(input logic [7:0] b, input logic [1:0] m, input string tag);
    cyc(1, b, m, 0, 1, tag);
    for (int i = 0; i < (8 >> m); i++) cyc(0, 8'h00, m, 1, 1, tag);
    cyc(0, 8'h00, m, 1, 1, "R9");
    cyc(0, 8'h00, m, 0, 1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    total++;
    if (index_o !== 8'd0) begin
      bad++;
      $display("FAIL R1: index_o=%02h expected=00 during reset", index_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 8'h00, 2'd0, 0, 1, "R1");
    cyc(0, 8'h00, 2'd0, 1, 1, "R1");

    run_byte(8'hB4, 2'd0, "R2");
    run_byte(8'h9C, 2'd1, "R3");
    run_byte(8'h4D, 2'd1, "R3");
    run_byte(8'hA7, 2'd2, "R4");
    run_byte(8'h5E, 2'd3, "R5");
    run_byte(8'hC3, 2'd3, "R5");

    // R6: load and advance on the same edge
    cyc(1, 8'h6B, 2'd0, 0, 1, "R6");
    cyc(0, 8'h00, 2'd0, 1, 1, "R6");
    cyc(1, 8'hE1, 2'd2, 1, 1, "R6");
    cyc(0, 8'h00, 2'd2, 0, 1, "R6");
    cyc(0, 8'h00, 2'd2, 1, 1, "R6");

    // R7: blanking keeps state
    cyc(1, 8'h3A, 2'd1, 0, 0, "R7");
    cyc(0, 8'h00, 2'd1, 0, 0, "R7");
    cyc(0, 8'h00, 2'd1, 0, 0, "R7");
    cyc(0, 8'h00, 2'd1, 1, 1, "R7");
    cyc(0, 8'h00, 2'd1, 0, 1, "R7");

    // R8: depth input changes between loads are ignored
    cyc(1, 8'hD6, 2'd1, 0, 1, "R8");
    cyc(0, 8'h00, 2'd3, 1, 1, "R8");
    cyc(0, 8'h00, 2'd0, 1, 1, "R8");
    cyc(0, 8'h00, 2'd2, 1, 1, "R8");
    cyc(0, 8'h00, 2'd0, 0, 1, "R8");

    // R10: hold without strobes
    cyc(1, 8'h72, 2'd0, 0, 1, "R10");
    cyc(0, 8'h00, 2'd0, 1, 1, "R10");
    for (int i = 0; i < 4; i++) cyc(0, 8'hFF, 2'd0, 0, 1, "R10");
    cyc(0, 8'h00, 2'd0, 0, 1, "R10");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule